// File: doc/BRIEF.md
# Multicycle Integer Multiplier with Memory-Stage Stall

This unit performs 32-by-32 integer multiplication, signed or unsigned, alongside an in-order five-stage pipeline. A multiply is accepted while its instruction sits in execute. The unit then works on it across one or two extra clocks while the instruction waits in the memory stage, and it raises a stall request for exactly those clocks. A narrow second operand finishes after one stall clock. A full-width second operand needs a second array pass first, so it stalls for two clocks.

When the arithmetic is done, the product is parked in a holding register. The pipeline may keep the instruction in the memory stage for longer, or it may kill it. The product only becomes architectural in the cycle the instruction has moved on to align. In that cycle a one-clock valid pulse is raised and the committed product is shown. If the operation was marked for the HI/LO pair, the upper word is written to HI and the lower word to LO. A kill before that point discards the work and leaves HI/LO untouched. A new multiply may enter execute in the same cycle the previous one leaves the memory stage.

Top module: `mul_stall_unit`

## Requirements
- R1: While reset is asserted and right after it, stall, res_valid, product, hi and lo are all zero.
- R2: An operation takes the short path when op_b bits 31..16 all equal (is_signed AND op_b bit 15). Otherwise it takes the long path.
- R3: A short-path operation holds stall high for exactly one cycle, starting the cycle after start is sampled.
- R4: A long-path operation holds stall high for exactly two consecutive cycles, starting the cycle after start is sampled.
- R5: The committed product equals the low 64 bits of op_a times op_b. Both are read as two's complement when is_signed is 1 and as unsigned values when it is 0.
- R6: res_valid rises only in the cycle after a clock edge that saw m_adv high, stall low and kill low with a finished operation waiting. Before that edge, the result stays held and nothing is committed, however many cycles pass.
- R7: At commit, if to_hilo was 1 when the operation started, hi takes product bits 63..32 and lo takes bits 31..0. If it was 0, hi and lo keep their values. hi, lo and product never change outside a commit.
- R8: kill asserted at any point before commit discards the operation. No res_valid follows, hi and lo are unchanged, and stall is low in the next cycle.
- R9: A start sampled in the same cycle that a held result commits is accepted. It stalls and completes as an independent operation.
- R10: res_valid is a single-cycle pulse per committed operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | A multiply is in execute; operands are valid |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; its upper half selects the path |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| to_hilo | input | 1 | 1: write the product to HI/LO at commit |
| m_adv | input | 1 | Pipeline wants to move the memory-stage instruction to align |
| kill | input | 1 | Discard the operation in flight |
| stall | output | 1 | Hold the pipeline in the memory stage |
| res_valid | output | 1 | One-cycle pulse: product committed |
| product | output | 64 | Last committed product |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |

## Verification
The assertions rely on the pipeline keeping to the unit's protocol. start is raised only when the unit is idle, or in the cycle a held result leaves with m_adv. start never coincides with kill. m_adv has effect only once stall is low. The stimulus follows these rules by construction. Each operation is issued by one task, and that task releases the next start only after the previous operation has committed or been killed, or on the exact advancing cycle for back-to-back issue. Operand values are steered so that both paths are hit: bit-15 sign boundaries, all-ones and most-negative operands, and a stream of pseudo-random pairs.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARR2 = 2'd1,
        ST_CPA  = 2'd2,
        ST_HOLD = 2'd3
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic arr2;
        logic cpa;
        logic commit;
        logic stall;
    } mul_ctl_t;

endpackage

// File: rtl/mul_width_sel.sv
module mul_width_sel #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_b,
    input  logic              is_signed,
    output logic              is_short
);
    localparam int SPLIT = DATA_W / 2;
    localparam int UPW   = DATA_W - SPLIT;

    logic fill;

    always_comb begin
        fill     = is_signed & op_b[SPLIT-1];
        is_short = (op_b[DATA_W-1:SPLIT] == {UPW{fill}});
    end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     is_short,
    input  logic     m_adv,
    input  logic     kill,
    output mul_ctl_t ctl
);
    mul_state_e state, nxt;

    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (start && !kill) begin
                    ctl.load = 1'b1;
                    nxt      = is_short ? ST_CPA : ST_ARR2;
                end
            end
            ST_ARR2: begin
                ctl.stall = 1'b1;
                if (kill) nxt = ST_IDLE;
                else begin
                    ctl.arr2 = 1'b1;
                    nxt      = ST_CPA;
                end
            end
            ST_CPA: begin
                ctl.stall = 1'b1;
                if (kill) nxt = ST_IDLE;
                else begin
                    ctl.cpa = 1'b1;
                    nxt     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (kill) nxt = ST_IDLE;
                else if (m_adv) begin
                    ctl.commit = 1'b1;
                    if (start) begin
                        ctl.load = 1'b1;
                        nxt      = is_short ? ST_CPA : ST_ARR2;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                arr2,
    input  logic                cpa,
    input  logic                is_short,
    input  logic                is_signed,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    output logic [2*DATA_W-1:0] sum_q
);
    localparam int SPLIT  = DATA_W / 2;
    localparam int AW     = DATA_W + 1;
    localparam int BLW    = SPLIT + 1;
    localparam int BHW    = DATA_W - SPLIT + 1;
    localparam int PPW    = AW + BLW;
    localparam int PROD_W = 2 * DATA_W;

    logic signed [AW-1:0]  a_ext, a_q;
    logic signed [BHW-1:0] bh_n, bh_q;
    logic signed [PPW-1:0] a_sx, a_q_sx, bl_sx, bh_sx;
    logic signed [PPW-1:0] pp_lo_n, pp_hi_first, pp_hi_second;
    logic signed [PPW-1:0] pp_lo_q, pp_hi_q;
    logic [PROD_W-1:0]     sum_n;

    always_comb begin
        a_ext  = {is_signed & op_a[DATA_W-1], op_a};
        bh_n   = {is_signed & op_b[DATA_W-1], op_b[DATA_W-1:SPLIT]};
        a_sx   = {{(PPW-AW){a_ext[AW-1]}}, a_ext};
        bl_sx  = {{(PPW-BLW){1'b0}}, 1'b0, op_b[SPLIT-1:0]};
        // First array pass: full first operand times the low half of the second.
        pp_lo_n = a_sx * bl_sx;
        // A narrow upper half is 0 or -1, so its partial product is 0 or -a.
        pp_hi_first = (is_short && bh_n[BHW-1]) ? -a_sx : '0;
        // Second array pass for wide operands, from the captured values.
        a_q_sx = {{(PPW-AW){a_q[AW-1]}}, a_q};
        bh_sx  = {{(PPW-BHW){bh_q[BHW-1]}}, bh_q};
        pp_hi_second = a_q_sx * bh_sx;
        // Final carry-propagate add of the two aligned partial products.
        sum_n = {{(PROD_W-PPW){pp_lo_q[PPW-1]}}, pp_lo_q}
              + ({{(PROD_W-PPW){pp_hi_q[PPW-1]}}, pp_hi_q} << SPLIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            bh_q    <= '0;
            pp_lo_q <= '0;
            pp_hi_q <= '0;
            sum_q   <= '0;
        end else begin
            if (load) begin
                a_q     <= a_ext;
                bh_q    <= bh_n;
                pp_lo_q <= pp_lo_n;
                pp_hi_q <= pp_hi_first;
            end else if (arr2) begin
                pp_hi_q <= pp_hi_second;
            end
            if (cpa) sum_q <= sum_n;
        end
    end
endmodule

// File: rtl/mul_stall_unit.sv
module mul_stall_unit
    import mul_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic                is_signed,
    input  logic                to_hilo,
    input  logic                m_adv,
    input  logic                kill,
    output logic                stall,
    output logic                res_valid,
    output logic [2*DATA_W-1:0] product,
    output logic [DATA_W-1:0]   hi,
    output logic [DATA_W-1:0]   lo
);
    localparam int PROD_W = 2 * DATA_W;

    mul_ctl_t          ctl;
    logic              is_short;
    logic              hilo_pend;
    logic [PROD_W-1:0] sum_q;

    mul_width_sel #(.DATA_W(DATA_W)) u_width (
        .op_b      (op_b),
        .is_signed (is_signed),
        .is_short  (is_short)
    );

    mul_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_short (is_short),
        .m_adv    (m_adv),
        .kill     (kill),
        .ctl      (ctl)
    );

    mul_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .arr2      (ctl.arr2),
        .cpa       (ctl.cpa),
        .is_short  (is_short),
        .is_signed (is_signed),
        .op_a      (op_a),
        .op_b      (op_b),
        .sum_q     (sum_q)
    );

    assign stall = ctl.stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            hilo_pend <= 1'b0;
            res_valid <= 1'b0;
            product   <= '0;
            hi        <= '0;
            lo        <= '0;
        end else begin
            res_valid <= ctl.commit;
            if (ctl.commit) begin
                product <= sum_q;
                if (hilo_pend) begin
                    hi <= sum_q[PROD_W-1:DATA_W];
                    lo <= sum_q[DATA_W-1:0];
                end
            end
            if (ctl.load) hilo_pend <= to_hilo;
        end
    end
endmodule

// File: rtl/mul_stall_chk.sv
module mul_stall_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                m_adv,
    input logic                kill,
    input logic                stall,
    input logic                res_valid,
    input logic [2*DATA_W-1:0] product,
    input logic [DATA_W-1:0]   hi,
    input logic [DATA_W-1:0]   lo
);
    // R3
    start_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !kill && !stall) |=> stall);

    // R4
    stall_max_two_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |=> !stall);

    // R6
    commit_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(m_adv && !stall && !kill));

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R8
    kill_discards_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!res_valid && !stall));

    // R7
    hilo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(hi) && $stable(lo)));

    // R7
    product_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(product));
endmodule

bind mul_stall_unit mul_stall_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .m_adv     (m_adv),
    .kill      (kill),
    .stall     (stall),
    .res_valid (res_valid),
    .product   (product),
    .hi        (hi),
    .lo        (lo)
);

// File: tb/mul_stall_unit_bench.sv
module mul_stall_unit_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] p;
        logic        hilo;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst, start, is_signed, to_hilo, m_adv, kill;
    logic [31:0] op_a, op_b;
    logic        stall, res_valid;
    logic [63:0] product;
    logic [31:0] hi, lo;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];
    logic [31:0] model_hi = '0, model_lo = '0;
    exp_t next_e, held_e;
    int   next_stalls;

    always #(CLK_PERIOD/2) clk = ~clk;

    mul_stall_unit u_mul_stall_unit (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .is_signed(is_signed), .to_hilo(to_hilo), .m_adv(m_adv), .kill(kill),
        .stall(stall), .res_valid(res_valid), .product(product), .hi(hi), .lo(lo)
    );

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, logic sgn);
        logic [63:0] ax, bx;
        ax = sgn ? {{32{a[31]}}, a} : {32'b0, a};
        bx = sgn ? {{32{b[31]}}, b} : {32'b0, b};
        return ax * bx;
    endfunction

    // Monitor: pops the scoreboard on each commit (R5, R7).
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check(0, "R6", "commit with nothing expected", product, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(product == e.p, "R5", "product", product, e.p);
                if (e.hilo) begin
                    model_hi = e.p[63:32];
                    model_lo = e.p[31:0];
                end
                check({hi, lo} == {model_hi, model_lo}, "R7", "hi/lo", {hi, lo}, {model_hi, model_lo});
            end
        end
    end

    // Driver: set up a start for the coming edge.
    task automatic drive_start(logic [31:0] a, logic [31:0] b, logic sgn, logic hl);
        start = 1'b1; op_a = a; op_b = b; is_signed = sgn; to_hilo = hl;
        next_e.p    = ref_mul(a, b, sgn);
        next_e.hilo = hl;
        // R2: short when the upper half is a pure extension of bit 15
        next_stalls = (b[31:16] == {16{sgn & b[15]}}) ? 1 : 2;
    endtask

    // Called at the negedge right after start was sampled.
    task automatic await_hold(bit early);
        int cnt = 0;
        start = 1'b0;
        held_e = next_e;
        if (early) m_adv = 1'b1;
        while (stall) begin
            cnt++;
            @(negedge clk);
        end
        if (next_stalls == 1)
            check(cnt == 1, "R3", "short stall cycles", 64'(cnt), 64'd1);
        else
            check(cnt == 2, "R4", "long stall cycles", 64'(cnt), 64'd2);
    endtask

    task automatic retire(int delay, bit kill_it);
        for (int i = 0; i < delay; i++) begin
            m_adv = 1'b0;
            @(negedge clk);
            check(!res_valid && !stall, "R6", "held without advance", {62'b0, res_valid, stall}, 64'h0);
        end
        if (kill_it) begin
            m_adv = 1'b0;
            kill = 1'b1;
        end else begin
            m_adv = 1'b1;
            sb.push_back(held_e);
        end
        @(negedge clk);
        m_adv = 1'b0;
        kill = 1'b0;
        if (kill_it) begin
            check(!res_valid && !stall, "R8", "kill in hold", {62'b0, res_valid, stall}, 64'h0);
            check({hi, lo} == {model_hi, model_lo}, "R8", "hi/lo after kill", {hi, lo}, {model_hi, model_lo});
        end else begin
            check(res_valid, "R6", "commit after advance", {63'b0, res_valid}, 64'h1);
        end
        @(negedge clk);
        check(!res_valid, "R10", "valid pulse width", {63'b0, res_valid}, 64'h0);
    endtask

    task automatic run_op(logic [31:0] a, logic [31:0] b, logic sgn, logic hl, int delay, bit early);
        drive_start(a, b, sgn, hl);
        @(negedge clk);
        await_hold(early);
        retire(early ? 0 : delay, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0;
        is_signed = 1'b0; to_hilo = 1'b0; m_adv = 1'b0; kill = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({stall, res_valid} == 2'b00, "R1", "stall/valid in reset", {62'b0, stall, res_valid}, 64'h0);
        check(product == 64'h0, "R1", "product in reset", product, 64'h0);
        check({hi, lo} == 64'h0, "R1", "hi/lo in reset", {hi, lo}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!stall && !res_valid, "R1", "idle after reset", {62'b0, stall, res_valid}, 64'h0);

        // R2/R3 short paths, R5 products
        run_op(32'd1234, 32'd5678, 1'b0, 1'b1, 0, 1'b0);
        run_op(32'hFFFF_FFF9, 32'hFFFF_FFFD, 1'b1, 1'b1, 0, 1'b0);
        run_op(32'h7FFF_FFFF, 32'h0000_7FFF, 1'b1, 1'b1, 0, 1'b0);
        // R2 boundary: bit 15 set, upper zero -> long signed, short unsigned
        run_op(32'h1234_5678, 32'h0000_8000, 1'b1, 1'b1, 0, 1'b0);
        run_op(32'h1234_5678, 32'h0000_8000, 1'b0, 1'b1, 0, 1'b0);
        // R4 long paths
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFD, 1'b0, 1'b1, 0, 1'b0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 0, 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 0, 1'b0);
        // R7 no HI/LO write
        run_op(32'd3, 32'h0001_0000, 1'b0, 1'b0, 0, 1'b0);
        // R6 delayed advance and advance held during stall
        run_op(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1, 1'b1, 3, 1'b0);
        run_op(32'hCAFE_0001, 32'h0000_1234, 1'b0, 1'b1, 0, 1'b1);
        run_op(32'h0000_00FF, 32'h8765_4321, 1'b1, 1'b1, 0, 1'b1);

        // R8 kill in hold
        drive_start(32'h1111_1111, 32'h2222_2222, 1'b0, 1'b1);
        @(negedge clk);
        await_hold(1'b0);
        retire(2, 1'b1);
        // R8 kill during a long stall
        drive_start(32'h5555_5555, 32'h7777_7777, 1'b1, 1'b1);
        @(negedge clk);
        start = 1'b0;
        kill = 1'b1;
        @(negedge clk);
        kill = 1'b0;
        check(!stall && !res_valid, "R8", "kill during stall", {62'b0, stall, res_valid}, 64'h0);
        check({hi, lo} == {model_hi, model_lo}, "R8", "hi/lo after stall kill", {hi, lo}, {model_hi, model_lo});
        repeat (2) @(negedge clk);
        check(!res_valid, "R8", "no late commit", {63'b0, res_valid}, 64'h0);

        // R9 back-to-back issue on the advancing cycle
        drive_start(32'h0000_0007, 32'h0000_0009, 1'b0, 1'b1);
        @(negedge clk);
        await_hold(1'b0);
        drive_start(32'hF000_0001, 32'h0F00_0003, 1'b1, 1'b1);
        m_adv = 1'b1;
        sb.push_back(held_e);
        @(negedge clk);
        m_adv = 1'b0;
        check(res_valid, "R9", "first commit of pair", {63'b0, res_valid}, 64'h1);
        check(stall, "R9", "second op stalls", {63'b0, stall}, 64'h1);
        await_hold(1'b0);
        retire(1, 1'b0);

        // R5 pseudo-random stream
        ra = 32'h1357_9BDF;
        rb = 32'h2468_ACE0;
        for (int i = 0; i < 40; i++) begin
            ra = ra * 32'd1103515245 + 32'd12345;
            rb = rb * 32'd1664525 + 32'd1013904223;
            if (i % 3 == 0) rb = {{16{rb[15]}}, rb[15:0]};
            run_op(ra, rb, i[0], i % 4 != 3, i % 3, i % 5 == 0);
        end

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5", "scoreboard drained", 64'(sb.size()), 64'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule